// File: doc/BRIEF.md
# Tiled texture address generator

This block turns a texel coordinate pair into the byte offset of that texel inside a texture buffer whose texels are grouped into small rectangular tiles. Each tile is stored as one contiguous run of memory, and tiles follow one another across a texture row. It also runs the mapping backwards: given a byte offset, it returns the coordinates of the texel stored there. The backward mode lets an address sweep walk memory linearly while still knowing which texel each word belongs to.

The texture width is supplied with every request, so one instance serves textures of any width up to the parameter limit. The tile shape and the texel size are parameters, and each must be a power of two. Requests enter on a valid/ready handshake, with a direction bit that selects the forward or the backward mapping. Results leave on a second valid/ready handshake after two register stages. A stalled output holds the pipeline without losing or reordering requests. The low bits of the offset, which lie inside one 4 KB page, are presented on their own output, because a page-aligned buffer gives them the same value in the virtual and the physical address.

Top module: `tex_tile_addr`

## Requirements
- R1: During and directly after synchronous reset (rst_n low), out_valid is 0 and in_ready is 1.
- R2: A forward request (in_dir = 0) with width W and coordinates (x, y) returns out_offset = 4 * (16 * T + 4 * (y mod 4) + (x mod 4)), where T = (y div 4) * ceil(W / 4) + (x div 4). This assumes the default 4x4 tiles of 4-byte texels.
- R3: The tiles-per-row count ceil(W / 4) rounds up. A width that is not a multiple of 4, such as W = 5, therefore counts a partial tile as a whole one.
- R4: A backward request (in_dir = 1) with an offset that is a multiple of 4 returns the (x, y) of that texel, so feeding a forward result back in returns the original coordinates.
- R5: A backward request whose offset has either of bits [1:0] set raises out_misalign and decodes the texel at offset div 4. Forward results always have out_misalign = 0.
- R6: out_page_ofs equals bits [11:0] of out_offset in both modes.
- R7: With out_ready held high, a request accepted in cycle c is presented with out_valid = 1 in cycle c + 2. The block accepts one request per cycle.
- R8: While out_valid = 1 and out_ready = 0, every output stays unchanged. With two requests in flight and the output stalled, in_ready is 0. No request is lost or reordered.
- R9: out_dir repeats the request's direction. In forward mode, out_x and out_y echo the request coordinates. In backward mode, out_offset echoes the request offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_dir | input | 1 | 0 = coordinates to offset, 1 = offset to coordinates |
| in_width | input | WB | Texture width in texels |
| in_x | input | CB | Texel column (forward mode) |
| in_y | input | CB | Texel row (forward mode) |
| in_offset | input | OB | Byte offset (backward mode) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed this cycle |
| out_dir | output | 1 | Direction of the result |
| out_offset | output | OB | Byte offset |
| out_x | output | CB | Texel column |
| out_y | output | CB | Texel row |
| out_misalign | output | 1 | Backward offset was not texel aligned |
| out_page_ofs | output | PAGE_BITS | Offset bits that lie inside one page |

## Verification
Forward and backward conversions share one pipeline, so a request of each direction can sit in the two stages at the same moment. Both can also be frozen there together by a stall. The bench provokes this by queuing each forward request directly before a backward request for the offset it should produce. It streams these pairs with random input gaps and random output stalls. Each result is checked, in order, against arithmetic for its own direction, and the backward result must give back the coordinates of the forward request that went in just before it.

// File: rtl/tex_tile_addr.sv
module tex_tile_addr #(
  parameter int TILE_W      = 4,
  parameter int TILE_H      = 4,
  parameter int TEXEL_BYTES = 4,
  parameter int WB          = 11,
  parameter int CB          = 11,
  parameter int OB          = 32,
  parameter int PAGE_BITS   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_dir,
  input  logic [WB-1:0]        in_width,
  input  logic [CB-1:0]        in_x,
  input  logic [CB-1:0]        in_y,
  input  logic [OB-1:0]        in_offset,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_dir,
  output logic [OB-1:0]        out_offset,
  output logic [CB-1:0]        out_x,
  output logic [CB-1:0]        out_y,
  output logic                 out_misalign,
  output logic [PAGE_BITS-1:0] out_page_ofs
);
  localparam int LTW = $clog2(TILE_W);
  localparam int LTH = $clog2(TILE_H);
  localparam int LTT = LTW + LTH;
  localparam int LBP = $clog2(TEXEL_BYTES);

  // stage 1 inputs
  logic [WB:0]     wsum;
  logic [WB-1:0]   tpr_c;
  logic [OB-1:0]   texel_c;
  logic [OB-1:0]   a_c, b_c;
  logic [LTT-1:0]  inner_c;

  assign wsum    = {1'b0, in_width} + (WB+1)'(TILE_W - 1);
  assign tpr_c   = WB'(wsum >> LTW);
  assign texel_c = in_offset >> LBP;
  assign a_c     = in_dir ? (texel_c >> LTT) : OB'(in_y >> LTH);
  assign b_c     = in_dir ? '0 : OB'(in_x >> LTW);
  assign inner_c = in_dir ? texel_c[LTT-1:0] : {in_y[LTH-1:0], in_x[LTW-1:0]};

  logic            s1_v, s1_dir, s1_mis;
  logic [WB-1:0]   s1_tpr;
  logic [OB-1:0]   s1_a, s1_b, s1_off;
  logic [LTT-1:0]  s1_inner;
  logic [CB-1:0]   s1_x, s1_y;

  logic s2_en;
  assign s2_en    = !out_valid || out_ready;
  assign in_ready = !s1_v || s2_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else if (in_ready) begin
      s1_v <= in_valid;
    end
    if (in_valid && in_ready) begin
      s1_dir   <= in_dir;
      s1_mis   <= in_dir && (|in_offset[LBP-1:0]);
      s1_tpr   <= tpr_c;
      s1_a     <= a_c;
      s1_b     <= b_c;
      s1_inner <= inner_c;
      s1_x     <= in_x;
      s1_y     <= in_y;
      s1_off   <= in_offset;
    end
  end

  // stage 2 arithmetic
  logic [OB-1:0] tpr_e, f_tile, f_off, i_row, i_col, i_x, i_y;
  logic          tpr_zero;

  assign tpr_e    = OB'(s1_tpr);
  assign tpr_zero = (s1_tpr == '0);
  assign f_tile   = s1_a * tpr_e + s1_b;
  assign f_off    = ((f_tile << LTT) | OB'(s1_inner)) << LBP;
  assign i_row    = tpr_zero ? '0 : s1_a / tpr_e;
  assign i_col    = tpr_zero ? '0 : s1_a % tpr_e;
  assign i_x      = (i_col << LTW) | OB'(s1_inner[LTW-1:0]);
  assign i_y      = (i_row << LTH) | OB'(s1_inner[LTT-1:LTW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (s2_en) begin
      out_valid <= s1_v;
    end
    if (s2_en && s1_v) begin
      out_dir      <= s1_dir;
      out_misalign <= s1_mis;
      out_offset   <= s1_dir ? s1_off : f_off;
      out_x        <= s1_dir ? CB'(i_x) : s1_x;
      out_y        <= s1_dir ? CB'(i_y) : s1_y;
    end
  end

  assign out_page_ofs = out_offset[PAGE_BITS-1:0];
endmodule

// File: rtl/tex_tile_addr_chk.sv
module tex_tile_addr_chk #(
  parameter int OB = 32,
  parameter int CB = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_dir,
  input logic          out_misalign,
  input logic [OB-1:0] out_offset,
  input logic [CB-1:0] out_x,
  input logic [CB-1:0] out_y
);
  logic [1:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 2'(in_valid && in_ready) - 2'(out_valid && out_ready);
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_x)
      && $stable(out_y) && $stable(out_dir) && $stable(out_misalign));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && inflight == 2'd2 |-> !in_ready);

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 2'd0);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight != 2'd3);

  // R5
  misalign_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_dir);
endmodule

bind tex_tile_addr tex_tile_addr_chk #(.OB(OB), .CB(CB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
  .out_misalign(out_misalign), .out_offset(out_offset), .out_x(out_x), .out_y(out_y)
);

// File: tb/tex_tile_addr_test.sv
module tex_tile_addr_test;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 11, CB = 11, OB = 32, PB = 12;
  localparam int NREQ = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_dir = 1'b0;
  logic [WB-1:0] in_width = '0;
  logic [CB-1:0] in_x = '0, in_y = '0;
  logic [OB-1:0] in_offset = '0;
  logic out_valid, out_ready = 1'b1, out_dir, out_misalign;
  logic [OB-1:0] out_offset;
  logic [CB-1:0] out_x, out_y;
  logic [PB-1:0] out_page_ofs;

  always #(CLK_PERIOD/2) clk = ~clk;

  tex_tile_addr uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_dir(in_dir),
    .in_width(in_width), .in_x(in_x), .in_y(in_y), .in_offset(in_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir), .out_offset(out_offset),
    .out_x(out_x), .out_y(out_y), .out_misalign(out_misalign), .out_page_ofs(out_page_ofs)
  );

  int tests = 0, fails = 0, cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 180000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<180000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint efwd(int w, int x, int y);
    int tpr = (w + 3) / 4;
    return longint'(((y / 4) * tpr + x / 4) * 64 + (y % 4) * 16 + (x % 4) * 4);
  endfunction

  function automatic void einv(int w, longint off, output int x, output int y);
    longint t = off / 4;
    longint tile = t / 16;
    int tpr = (w + 3) / 4;
    x = int'((tile % tpr) * 4 + t % 4);
    y = int'((tile / tpr) * 4 + (t % 16) / 4);
  endfunction

  bit     rq_dir [NREQ];
  int     rq_w [NREQ], rq_x [NREQ], rq_y [NREQ], rq_ex [NREQ], rq_ey [NREQ];
  longint rq_off [NREQ];
  int     rq_n;

  task automatic add_fwd(int w, int x, int y);
    rq_dir[rq_n] = 1'b0; rq_w[rq_n] = w; rq_x[rq_n] = x; rq_y[rq_n] = y;
    rq_off[rq_n] = efwd(w, x, y); rq_ex[rq_n] = x; rq_ey[rq_n] = y;
    rq_n++;
  endtask

  task automatic add_inv(int w, longint off);
    int ex, ey;
    einv(w, off, ex, ey);
    rq_dir[rq_n] = 1'b1; rq_w[rq_n] = w; rq_x[rq_n] = 0; rq_y[rq_n] = 0;
    rq_off[rq_n] = off; rq_ex[rq_n] = ex; rq_ey[rq_n] = ey;
    rq_n++;
  endtask

  task automatic check_out(int k);
    bit mis = rq_dir[k] && (rq_off[k] % 4 != 0);
    chk(out_dir == rq_dir[k], "R9 dir", longint'(out_dir), longint'(rq_dir[k]));
    chk(out_misalign == mis, "R5 misalign", longint'(out_misalign), longint'(mis));
    chk(out_page_ofs == PB'(rq_off[k]), "R6 page", longint'(out_page_ofs), rq_off[k] % 4096);
    if (!rq_dir[k]) begin
      chk(longint'(out_offset) == rq_off[k], (rq_w[k] % 4 != 0) ? "R3 offset" : "R2 offset",
          longint'(out_offset), rq_off[k]);
      chk(int'(out_x) == rq_x[k] && int'(out_y) == rq_y[k], "R9 coord echo",
          longint'(out_x), longint'(rq_x[k]));
    end else begin
      chk(int'(out_x) == rq_ex[k], mis ? "R5 x" : "R4 x", longint'(out_x), longint'(rq_ex[k]));
      chk(int'(out_y) == rq_ey[k], mis ? "R5 y" : "R4 y", longint'(out_y), longint'(rq_ey[k]));
      chk(longint'(out_offset) == rq_off[k], "R9 offset echo", longint'(out_offset), rq_off[k]);
    end
  endtask

  task automatic run_batch(int stall_pct, int gap_pct);
    int sent = 0, got = 0;
    bit hold = 1'b0;
    logic [OB-1:0] h_off;
    logic [CB-1:0] h_x, h_y;
    while (got < rq_n) begin
      @(negedge clk);
      if (hold) begin
        chk(out_valid && out_offset == h_off && out_x == h_x && out_y == h_y,
            "R8 hold", longint'(out_offset), longint'(h_off));
      end
      if (sent < rq_n && $urandom_range(99) >= gap_pct) begin
        in_valid  = 1'b1;
        in_dir    = rq_dir[sent];
        in_width  = WB'(rq_w[sent]);
        in_x      = CB'(rq_x[sent]);
        in_y      = CB'(rq_y[sent]);
        in_offset = OB'(rq_off[sent]);
      end else begin
        in_valid = 1'b0;
      end
      out_ready = ($urandom_range(99) >= stall_pct);
      #1;
      if (out_valid && !out_ready && sent - got == 2)
        chk(!in_ready, "R8 full stall", longint'(in_ready), 0);
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        check_out(got);
        got++;
      end
      hold  = out_valid && !out_ready;
      h_off = out_offset; h_x = out_x; h_y = out_y;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(in_ready, "R1 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 idle after reset", longint'(out_valid), 0);

    // R7 latency: W=8, (5,6) -> tile 3, texel 57, offset 228
    in_valid = 1'b1; in_dir = 1'b0; in_width = 8; in_x = 5; in_y = 6; out_ready = 1'b1;
    #1 chk(in_ready, "R7 accept", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R7 not early", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid, "R7 valid at c+2", longint'(out_valid), 1);
    chk(out_offset == 228, "R2 known offset", longint'(out_offset), 228);
    @(negedge clk);

    // R3 partial tile: W=5, (0,1): tpr 2, offset 16
    rq_n = 0;
    add_fwd(5, 0, 1);
    add_fwd(5, 4, 4);
    run_batch(0, 0);
    chk(efwd(5, 4, 4) == 4 * (16 * 3), "R3 model round-up", efwd(5, 4, 4), 192);

    // exhaustive small widths, forward then backward round trip, back to back
    rq_n = 0;
    for (int w = 1; w <= 12; w++)
      for (int y = 0; y < 6; y++)
        for (int x = 0; x < w; x++) begin
          add_fwd(w, x, y);
          add_inv(w, efwd(w, x, y));
        end
    run_batch(0, 0);
    rq_n = 0;
    for (int w = 1; w <= 12; w++)
      for (int y = 0; y < 6; y++)
        for (int x = 0; x < w; x++) begin
          add_fwd(w, x, y);
          add_inv(w, efwd(w, x, y));
        end
    run_batch(40, 30);

    // random widths 1..1024 with stalls (R8)
    for (int b = 0; b < 3; b++) begin
      rq_n = 0;
      for (int i = 0; i < 20; i++) begin
        int w = $urandom_range(1024, 1);
        for (int j = 0; j < 25; j++) begin
          int x = $urandom_range(w - 1, 0);
          int y = $urandom_range(255, 0);
          add_fwd(w, x, y);
          add_inv(w, efwd(w, x, y));
        end
      end
      run_batch(b * 30, b * 20);
    end

    // R5 misaligned backward offsets
    rq_n = 0;
    for (int i = 0; i < 300; i++) begin
      int w = $urandom_range(1024, 1);
      add_inv(w, longint'($urandom_range(200000, 0)));
    end
    add_inv(8, 230);
    run_batch(25, 10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule